// File: doc/BRIEF.md
# Pipeline Redirect Epoch Controller

This block tracks wrong-path state for an in-order pipeline in which two stages may steer fetch: decode, from a branch direction guess, and execute, from the resolved outcome. Each redirecting stage owns one epoch bit. Upstream stages hold their own copies of the downstream bits. Every fetched instruction is tagged with the fetch-side copies. Later stages compare those tags with their own state to decide whether the instruction is still on the right path.

Each cycle the block takes the instruction at decode and the instruction at execute. At decode it gets the tags and the predictor's disagreement flag. At execute it gets the tag, the mispredict flag, the resolved target and a write enable. It returns a keep/drop decision and a redirect flag for decode, and a poison flag and a gated write enable for execute. It also returns a new fetch PC with a valid strobe, plus the two tags for the next fetched instruction. An execute redirect always overrules a decode redirect. A decode redirect whose execute tag is out of date is discarded.

Top module: `redirect_epoch_ctrl`

## Requirements
- R1: After reset all five epoch bits are 0: `fe_tag_e` and `fe_tag_d` read 0, and `fe_pc_vld` stays low while no stage is valid.
- R2: `fe_tag_e` and `fe_tag_d` show the fetch-side copies of the execute and decode epochs. They change only on an accepted redirect.
- R3: An execute instruction that is not poisoned and has `ex_mispred`=1 drives `fe_pc_vld`=1 with `fe_pc`=`ex_next_pc` in the same cycle. It inverts `fe_tag_e` and the execute epoch from the next cycle.
- R4: When an execute redirect and a decode redirect occur in one cycle, `fe_pc` takes the execute target and `fe_tag_d` is left unchanged.
- R5: A decode redirect is accepted when there is no execute redirect and `de_ep_e` equals `fe_tag_e`. It drives `fe_pc`=`de_pred_pc` and inverts `fe_tag_d` from the next cycle.
- R6: A decode redirect whose `de_ep_e` differs from `fe_tag_e` is discarded. `fe_pc_vld` stays low and both fetch tags hold.
- R7: A decode instruction whose `de_ep_e` differs from decode's execute-epoch copy is kept. Decode adopts that tag and sets its own epoch to `de_ep_d`.
- R8: A decode instruction whose `de_ep_e` matches decode's copy is kept only when `de_ep_d` equals decode's own epoch. Otherwise it is dropped and raises no redirect.
- R9: A kept instruction with `de_mismatch`=1 raises `de_redir` and inverts decode's epoch. A later instruction still carrying the old decode tag is dropped.
- R10: An execute instruction whose `ex_ep` differs from the execute epoch is poisoned. It forces `ex_wr_en_o` low and causes no redirect even when `ex_mispred`=1.
- R11: When decode adopts new tags and also redirects in one cycle, its epoch becomes the inverse of `de_ep_d`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_vld | input | 1 | Execute stage holds an instruction |
| ex_ep | input | 1 | Execute-epoch tag of that instruction |
| ex_mispred | input | 1 | Resolved next PC differs from the predicted one |
| ex_next_pc | input | PC_W | Resolved next PC |
| ex_wr_en_i | input | 1 | Architectural write enable from execute |
| ex_poison | output | 1 | Execute instruction is on a wrong path |
| ex_wr_en_o | output | 1 | Write enable gated by poison |
| de_vld | input | 1 | Decode stage holds an instruction |
| de_ep_e | input | 1 | Execute-epoch tag of the decode instruction |
| de_ep_d | input | 1 | Decode-epoch tag of the decode instruction |
| de_mismatch | input | 1 | Decode predictor disagrees with the fetch prediction |
| de_pred_pc | input | PC_W | Decode predictor's next PC |
| de_keep | output | 1 | Decode instruction proceeds |
| de_redir | output | 1 | Decode issues a redirect |
| fe_pc_vld | output | 1 | Fetch PC is being redirected this cycle |
| fe_pc | output | PC_W | Redirect target for fetch |
| fe_tag_e | output | 1 | Execute-epoch tag for the next fetched instruction |
| fe_tag_d | output | 1 | Decode-epoch tag for the next fetched instruction |

## Verification
A directed sequence first walks through specific cases. It sends a decode redirect on its own. It then sends the same decode tag again after the epoch has moved on, to show the drop. It collides an execute redirect with a decode redirect, to separate priority from acceptance. It replays an execute instruction with a stale tag, to show poisoning rather than a second redirect. It presents an adopt-and-redirect instruction, to pin down the inverted epoch. It sends a decode redirect carrying an outdated execute tag, to show it being discarded. A long stretch of random tags, flags and targets then mixes these cases in orders the directed part does not reach, and the behavioural model is compared with every output on every cycle.

// File: rtl/redirect_epoch_ctrl.sv
module redirect_epoch_ctrl #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_vld,
  input  logic            ex_ep,
  input  logic            ex_mispred,
  input  logic [PC_W-1:0] ex_next_pc,
  input  logic            ex_wr_en_i,
  output logic            ex_poison,
  output logic            ex_wr_en_o,
  input  logic            de_vld,
  input  logic            de_ep_e,
  input  logic            de_ep_d,
  input  logic            de_mismatch,
  input  logic [PC_W-1:0] de_pred_pc,
  output logic            de_keep,
  output logic            de_redir,
  output logic            fe_pc_vld,
  output logic [PC_W-1:0] fe_pc,
  output logic            fe_tag_e,
  output logic            fe_tag_d
);

  logic ex_epoch, dec_epoch, dec_ex_copy, fe_ex_copy, fe_dec_copy;
  logic ex_redir, dec_take;

  assign ex_poison  = ex_vld && (ex_ep != ex_epoch);
  assign ex_wr_en_o = ex_wr_en_i && !ex_poison;
  assign ex_redir   = ex_vld && !ex_poison && ex_mispred;

  assign de_keep  = de_vld && ((de_ep_e != dec_ex_copy) || (de_ep_d == dec_epoch));
  assign de_redir = de_keep && de_mismatch;
  assign dec_take = de_redir && !ex_redir && (de_ep_e == fe_ex_copy);

  assign fe_pc_vld = ex_redir || dec_take;
  assign fe_pc     = ex_redir ? ex_next_pc : de_pred_pc;
  assign fe_tag_e  = fe_ex_copy;
  assign fe_tag_d  = fe_dec_copy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_epoch    <= 1'b0;
      dec_epoch   <= 1'b0;
      dec_ex_copy <= 1'b0;
      fe_ex_copy  <= 1'b0;
      fe_dec_copy <= 1'b0;
    end else begin
      if (ex_redir) begin
        ex_epoch   <= !ex_epoch;
        fe_ex_copy <= !fe_ex_copy;
      end
      if (dec_take)
        fe_dec_copy <= !fe_dec_copy;
      if (de_keep) begin
        dec_ex_copy <= de_ep_e;
        dec_epoch   <= de_ep_d ^ de_mismatch;
      end
    end
  end

  // R3
  ex_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld && !ex_poison && ex_mispred) |=> (fe_tag_e != $past(fe_tag_e)));

  // R2
  fe_tag_e_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ex_vld && ex_mispred) |=> $stable(fe_tag_e));

  // R4
  ex_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_redir && de_redir) |=> $stable(fe_tag_d));

  // R6
  stale_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_redir && !(ex_vld && ex_mispred) && de_ep_e != fe_tag_e) |-> !fe_pc_vld);

  // R8
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_vld && !de_keep) |-> !de_redir);

  // R10
  poison_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_poison |-> (!ex_wr_en_o && !fe_pc_vld) || de_redir);

endmodule

// File: tb/redirect_epoch_ctrl_tb.sv
module redirect_epoch_ctrl_tb;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_vld = 0, ex_ep = 0, ex_mispred = 0, ex_wr_en_i = 0;
  logic [PC_W-1:0] ex_next_pc = '0, de_pred_pc = '0;
  logic de_vld = 0, de_ep_e = 0, de_ep_d = 0, de_mismatch = 0;
  logic ex_poison, ex_wr_en_o, de_keep, de_redir, fe_pc_vld, fe_tag_e, fe_tag_d;
  logic [PC_W-1:0] fe_pc;

  int checks = 0;
  int errors = 0;
  int m_ex = 0, m_dd = 0, m_de = 0, m_fe = 0, m_fd = 0;

  always #10 clk = ~clk;

  redirect_epoch_ctrl #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ex_vld(ex_vld), .ex_ep(ex_ep), .ex_mispred(ex_mispred),
    .ex_next_pc(ex_next_pc), .ex_wr_en_i(ex_wr_en_i),
    .ex_poison(ex_poison), .ex_wr_en_o(ex_wr_en_o),
    .de_vld(de_vld), .de_ep_e(de_ep_e), .de_ep_d(de_ep_d),
    .de_mismatch(de_mismatch), .de_pred_pc(de_pred_pc),
    .de_keep(de_keep), .de_redir(de_redir),
    .fe_pc_vld(fe_pc_vld), .fe_pc(fe_pc),
    .fe_tag_e(fe_tag_e), .fe_tag_d(fe_tag_d)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit xv, input bit xe, input bit xm, input bit xw,
                     input bit dv, input bit dte, input bit dtd, input bit dm,
                     input logic [PC_W-1:0] xpc, input logic [PC_W-1:0] dpc);
    bit pois, xr, keep, dr, dt;
    string kt, pt;
    ex_vld = xv; ex_ep = xe; ex_mispred = xm; ex_wr_en_i = xw; ex_next_pc = xpc;
    de_vld = dv; de_ep_e = dte; de_ep_d = dtd; de_mismatch = dm; de_pred_pc = dpc;
    pois = xv && (int'(xe) != m_ex);
    xr   = xv && !pois && xm;
    if (!dv) keep = 0;
    else if (int'(dte) != m_de) keep = 1;
    else keep = (int'(dtd) == m_dd);
    dr = keep && dm;
    dt = dr && !xr && (int'(dte) == m_fe);
    kt = (dv && int'(dte) != m_de) ? "R7 keep" : "R8 keep";
    if (xr) pt = dr ? "R4 pc" : "R3 pc";
    else pt = dr ? (dt ? "R5 pc" : "R6 pc") : "R3 pc";
    #8;
    chk("R10 poison", ex_poison, pois);
    chk("R10 wr_en", ex_wr_en_o, xw && !pois);
    chk(kt, de_keep, keep);
    chk("R9 de_redir", de_redir, dr);
    chk(pt, fe_pc_vld, xr || dt);
    if (xr) chk("R4 target", fe_pc, xpc);
    else if (dt) chk("R5 target", fe_pc, dpc);
    chk("R2 tag_e", fe_tag_e, m_fe);
    chk("R2 tag_d", fe_tag_d, m_fd);
    @(posedge clk);
    if (xr) begin m_ex ^= 1; m_fe ^= 1; end
    if (dt) m_fd ^= 1;
    if (keep) begin m_de = dte; m_dd = dtd ^ dm; end
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 tag_e", fe_tag_e, 0);
    chk("R1 tag_d", fe_tag_d, 0);
    chk("R1 pc_vld", fe_pc_vld, 0);
    // R5: lone decode redirect
    cyc(0,0,0,0, 1,0,0,1, 32'h0, 32'h100);
    // R9: old decode tag now dropped
    cyc(0,0,0,0, 1,0,0,0, 32'h0, 32'h0);
    chk("R9 drop_old", de_keep, 0);
    cyc(0,0,0,0, 1,0,1,0, 32'h0, 32'h0);
    // R4: collision, execute wins
    cyc(1,0,1,1, 1,0,1,1, 32'h200, 32'h300);
    // R10: stale execute tag poisoned
    cyc(1,0,1,1, 0,0,0,0, 32'h400, 32'h0);
    chk("R10 tag_e_hold", fe_tag_e, 1);
    // R11: adopt and redirect together
    cyc(0,0,0,0, 1,1,0,1, 32'h0, 32'h500);
    cyc(0,0,0,0, 1,1,0,0, 32'h0, 32'h0);
    chk("R11 old_d_dropped", de_keep, 0);
    cyc(0,0,0,0, 1,1,1,0, 32'h0, 32'h0);
    chk("R11 inverted_d_kept", de_keep, 1);
    // R6: decode redirect with outdated execute tag
    cyc(0,0,0,0, 1,0,0,1, 32'h0, 32'h600);
    chk("R6 tag_d_hold", fe_tag_d, 0);
    for (int i = 0; i < 3000; i++)
      cyc($urandom%2, $urandom%2, $urandom%2, $urandom%2,
          $urandom%2, $urandom%2, $urandom%2, $urandom%2,
          $urandom, $urandom);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule